// File: doc/BRIEF.md
# Gauss-Jordan Row Engine

This block is one lane of a parallel Gauss-Jordan solver. A solver holds one engine per matrix row. Each engine keeps its row of the augmented matrix, the coefficients followed by the right-hand side, in a private dual-port memory. Each engine also carries a fixed row number. A central sequencer broadcasts a phase code and a reference row number to every engine, then pulses a start strobe. Each engine compares the reference with its own number. From that comparison and the phase it decides what its next vector operation is.

During an elimination step the engine whose number matches the reference is the pivot owner. It divides every element of its row by its diagonal entry, writes the quotients back, and streams them out in column order. Every other engine first fetches its own entry in the pivot column as a scale factor. It then takes the streamed pivot row one element per cycle and subtracts the scaled element from its own entry. This update is pipelined: the read-only memory port fetches the next operand while the read-write port stores the previous result. In the return phase the owner hands out its right-hand-side value. Values are signed fixed point with 16 fraction bits and saturate at the ends of the range.

Top module: `gj_row_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, done_o, nrm_valid_o, ret_valid_o and div_err_o are all low.
- R2: With phase_i = 1 (load) and ref_row_i equal to the engine's number, each cycle with ld_valid_i high stores ld_data_i into column ld_col_i. With any other reference row, load writes leave the row unchanged.
- R3: A start in phase 0 (idle) or 1 (load) is acknowledged by done_o high in the cycle after the start, for exactly one cycle.
- R4: A start in phase 2 with ref_row_i equal to the engine's number normalizes the row. Column d = ref_row_i-1 is the diagonal. Every column x is replaced by trunc(x*2^16/d), saturated to [-2^23, 2^23-1]. Each quotient appears on nrm_data_o with nrm_col_o in ascending order 0..N. done_o follows the last quotient.
- R5: If the diagonal is zero, normalization produces no nrm_valid_o pulse and leaves the row unchanged. div_err_o is high when done_o rises, and it stays high until the next start.
- R6: A start in phase 2 with ref_row_i different from the engine's number captures f = own entry at column ref_row_i-1. Each accepted broadcast element (column c, value b) then sets row[c] = sat(row[c] - floor(f*b/2^16)). One element is accepted per cycle, in any column order. done_o rises two cycles after the clock edge that samples the (N+1)-th element.
- R7: Broadcast elements presented in the first two cycles after the start cycle are ignored.
- R8: A start in phase 3 (return) with a matching reference row raises ret_valid_o for one cycle, two cycles after the start, carrying the right-hand side (column N). done_o follows in the next cycle.
- R9: A start in phase 3 with a non-matching reference row gives done_o in the cycle after the start, and ret_valid_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_i | input | 2 | Solution phase: 0 idle, 1 load, 2 eliminate, 3 return |
| ref_row_i | input | IDW | Reference row number, 1-based |
| start_i | input | 1 | Start the operation selected by phase and reference |
| ld_valid_i | input | 1 | Load write strobe |
| ld_col_i | input | AW | Load column index |
| ld_data_i | input | DW | Load value, Q8.16 |
| bc_valid_i | input | 1 | Broadcast pivot-row element strobe |
| bc_col_i | input | AW | Broadcast element column |
| bc_data_i | input | DW | Broadcast element value |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| nrm_valid_o | output | 1 | Normalized element strobe (pivot owner) |
| nrm_col_o | output | AW | Normalized element column |
| nrm_data_o | output | DW | Normalized element value |
| ret_valid_o | output | 1 | Returned right-hand-side strobe |
| ret_data_o | output | DW | Returned right-hand-side value |
| div_err_o | output | 1 | Zero diagonal seen in the last normalization |

## Verification
The bench keeps a model of the row and sweeps many rows through load, eliminate, normalize and return. Along the way it rotates the order in which broadcast columns arrive. A design that tied the update to arrival position instead of the carried column index would corrupt the row. A design that captured the factor after its own column had been updated would also corrupt it, and later quotients would show the error. Saturation is driven from both sides in the divider and in the multiply-subtract path; a missing clamp would show up as a wrapped value. The bench also injects a stray broadcast before the engine is ready, a load aimed at another row, and a zero diagonal. These catch designs that accept early data, obey foreign loads, or divide by zero.

// File: rtl/gj_pkg.sv
// Shared types for the Gauss-Jordan row engine.
package gj_pkg;

    // Solution phase as broadcast by the central sequencer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_ELIM = 2'd2,
        PH_RET  = 2'd3
    } phase_e;

    // Engine controller states.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FAC_RD,
        ST_FAC_CAP,
        ST_RUN,
        ST_DEN_RD,
        ST_DEN_CAP,
        ST_NRM_RD,
        ST_NRM_GO,
        ST_NRM_WAIT,
        ST_RET_RD,
        ST_RET_OUT,
        ST_DONE
    } state_e;

endpackage

// File: rtl/gj_pos_decode.sv
// Position decoder: flags whether the broadcast reference row is this
// engine's own row. Assumes ROW_ID fits in IDW bits.
module gj_pos_decode #(
    parameter int IDW    = 4,
    parameter int ROW_ID = 1
) (
    input  logic [IDW-1:0] ref_row_i,
    output logic           equal_o
);

    localparam logic [IDW-1:0] MY_ID = IDW'(ROW_ID);

    // Compare the broadcast reference against the fixed row number.
    assign equal_o = (ref_row_i == MY_ID);

endmodule

// File: rtl/gj_row_mem.sv
// Row store with one read-only port (upper control) and one read-write
// port (lower control). Both ports have a one-cycle registered read.
// The array itself is not reset; rows are loaded before use.
module gj_row_mem #(
    parameter int DW    = 24,
    parameter int DEPTH = 9,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          ra_en_i,
    input  logic [AW-1:0] ra_addr_i,
    output logic [DW-1:0] ra_q_o,
    input  logic          wb_en_i,
    input  logic          wb_we_i,
    input  logic [AW-1:0] wb_addr_i,
    input  logic [DW-1:0] wb_d_i,
    output logic [DW-1:0] wb_q_o
);

    logic [DW-1:0] mem [DEPTH];

    // Read-only port: registered read.
    always_ff @(posedge clk) begin
        if (ra_en_i) begin
            ra_q_o <= mem[ra_addr_i];
        end
    end

    // Read-write port: write, or registered read when not writing.
    always_ff @(posedge clk) begin
        if (wb_en_i) begin
            if (wb_we_i) begin
                mem[wb_addr_i] <= wb_d_i;
            end else begin
                wb_q_o <= mem[wb_addr_i];
            end
        end
    end

endmodule

// File: rtl/gj_div.sv
// Multi-cycle restoring divider for signed fixed point.
// Result = trunc(num * 2^FRAC / den), saturated to the signed DW range.
// Takes DW+FRAC cycles after go_i; done_o pulses when quo_o is final.
// Assumes den_i is nonzero (the caller screens out zero).
module gj_div #(
    parameter int DW   = 24,
    parameter int FRAC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [DW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic          done_o,
    output logic [DW-1:0] quo_o
);

    localparam int ITER = DW + FRAC;
    localparam int CW   = $clog2(ITER + 1);
    localparam logic [DW-1:0] ONE  = DW'(1);
    localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic            busy_q, done_q, neg_q;
    logic [CW-1:0]   cnt_q;
    logic [ITER-1:0] dvd_q, q_q;
    logic [DW-1:0]   dmag_q, rem_q;
    logic [DW-1:0]   num_mag, den_mag;
    logic [DW:0]     trial, diffv;
    logic            fits, ovf_pos, ovf_neg;

    // Operand magnitudes.
    assign num_mag = num_i[DW-1] ? (~num_i + ONE) : num_i;
    assign den_mag = den_i[DW-1] ? (~den_i + ONE) : den_i;

    // One restoring step: shift in the next dividend bit and try to subtract.
    assign trial = {rem_q, dvd_q[ITER-1]};
    assign diffv = trial - {1'b0, dmag_q};
    assign fits  = ~diffv[DW];

    // Iteration state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            neg_q  <= 1'b0;
            cnt_q  <= '0;
            dvd_q  <= '0;
            q_q    <= '0;
            dmag_q <= '0;
            rem_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (go_i) begin
                busy_q <= 1'b1;
                neg_q  <= num_i[DW-1] ^ den_i[DW-1];
                cnt_q  <= CW'(ITER);
                dvd_q  <= {num_mag, {FRAC{1'b0}}};
                q_q    <= '0;
                dmag_q <= den_mag;
                rem_q  <= '0;
            end else if (busy_q) begin
                dvd_q <= dvd_q << 1;
                rem_q <= fits ? diffv[DW-1:0] : trial[DW-1:0];
                q_q   <= {q_q[ITER-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Sign restore and saturation of the quotient magnitude.
    assign ovf_pos = |q_q[ITER-1:DW-1];
    assign ovf_neg = (|q_q[ITER-1:DW]) | (q_q[DW-1] & (|q_q[DW-2:0]));

    always_comb begin
        if (neg_q) begin
            quo_o = ovf_neg ? MINV : (~q_q[DW-1:0] + ONE);
        end else begin
            quo_o = ovf_pos ? MAXV : q_q[DW-1:0];
        end
    end

    assign done_o = done_q;

endmodule

// File: rtl/gj_vec_alu.sv
// Elimination datapath: res = sat(row - floor(fac * b / 2^FRAC)).
// Purely combinational; the caller registers around it.
module gj_vec_alu #(
    parameter int DW   = 24,
    parameter int FRAC = 16
) (
    input  logic signed [DW-1:0] row_i,
    input  logic signed [DW-1:0] fac_i,
    input  logic signed [DW-1:0] b_i,
    output logic        [DW-1:0] res_o
);

    localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic signed [2*DW-1:0] prod, scaled;
    logic signed [2*DW:0]   diff;
    logic                   in_range;

    // Scaled product and wide difference.
    assign prod   = fac_i * b_i;
    assign scaled = prod >>> FRAC;
    assign diff   = (2*DW+1)'(row_i) - (2*DW+1)'(scaled);

    // Clamp when the bits above the result's sign bit disagree.
    assign in_range = (&diff[2*DW:DW-1]) | ~(|diff[2*DW:DW-1]);
    assign res_o    = in_range ? diff[DW-1:0] : (diff[2*DW] ? MINV : MAXV);

endmodule

// File: rtl/gj_row_engine.sv
// One row engine of a parallel Gauss-Jordan solver.
// Holds row ROW_ID (1-based) of an N_ROWS x (N_ROWS+1) augmented matrix in
// Q(DW-FRAC).FRAC fixed point. It decodes phase and reference row into load,
// normalize, eliminate or return, and runs the vector operation.
// Assumes phase_i and ref_row_i stay stable from start_i until done_o.
module gj_row_engine
    import gj_pkg::*;
#(
    parameter  int N_ROWS = 8,
    parameter  int ROW_ID = 1,
    parameter  int DW     = 24,
    parameter  int FRAC   = 16,
    localparam int COLS   = N_ROWS + 1,
    localparam int AW     = $clog2(COLS),
    localparam int IDW    = AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     phase_i,
    input  logic [IDW-1:0] ref_row_i,
    input  logic           start_i,
    input  logic           ld_valid_i,
    input  logic [AW-1:0]  ld_col_i,
    input  logic [DW-1:0]  ld_data_i,
    input  logic           bc_valid_i,
    input  logic [AW-1:0]  bc_col_i,
    input  logic [DW-1:0]  bc_data_i,
    output logic           done_o,
    output logic           nrm_valid_o,
    output logic [AW-1:0]  nrm_col_o,
    output logic [DW-1:0]  nrm_data_o,
    output logic           ret_valid_o,
    output logic [DW-1:0]  ret_data_o,
    output logic           div_err_o
);

    localparam logic [AW-1:0]  LAST_COL = AW'(COLS - 1);
    localparam logic [IDW-1:0] ONE_ID   = IDW'(1);

    phase_e         ph;
    state_e         st_q, st_d;
    logic           pos_equal;
    logic [AW-1:0]  ref_idx;
    logic [AW-1:0]  col_q, cnt_q;
    logic [DW-1:0]  fac_q, den_q;
    logic           err_q;
    logic           s1_v_q;
    logic [AW-1:0]  s1_col_q;
    logic [DW-1:0]  s1_b_q;
    logic           run_last;

    logic           ra_en, wb_en, wb_we;
    logic [AW-1:0]  ra_addr, wb_addr;
    logic [DW-1:0]  ra_q, wb_q, wb_d;
    logic           div_go, div_done;
    logic [DW-1:0]  div_quo, alu_res;

    assign ph      = phase_e'(phase_i);
    assign ref_idx = AW'(ref_row_i - ONE_ID);

    gj_pos_decode #(.IDW(IDW), .ROW_ID(ROW_ID)) u_pos (
        .ref_row_i (ref_row_i),
        .equal_o   (pos_equal)
    );

    gj_row_mem #(.DW(DW), .DEPTH(COLS), .AW(AW)) u_mem (
        .clk       (clk),
        .ra_en_i   (ra_en),
        .ra_addr_i (ra_addr),
        .ra_q_o    (ra_q),
        .wb_en_i   (wb_en),
        .wb_we_i   (wb_we),
        .wb_addr_i (wb_addr),
        .wb_d_i    (wb_d),
        .wb_q_o    (wb_q)
    );

    gj_div #(.DW(DW), .FRAC(FRAC)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (div_go),
        .num_i  (ra_q),
        .den_i  (den_q),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    gj_vec_alu #(.DW(DW), .FRAC(FRAC)) u_alu (
        .row_i (ra_q),
        .fac_i (fac_q),
        .b_i   (s1_b_q),
        .res_o (alu_res)
    );

    // The last elimination write happens when the final stage-1 element retires.
    assign run_last = s1_v_q && (cnt_q == LAST_COL);

    // Memory port and divider control for each state (upper read / lower write).
    always_comb begin
        ra_en   = 1'b0;
        ra_addr = ref_idx;
        wb_en   = 1'b0;
        wb_we   = 1'b0;
        wb_addr = '0;
        wb_d    = '0;
        div_go  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (ph == PH_LOAD && pos_equal && ld_valid_i) begin
                    wb_en   = 1'b1;
                    wb_we   = 1'b1;
                    wb_addr = ld_col_i;
                    wb_d    = ld_data_i;
                end
            end
            ST_FAC_RD, ST_DEN_RD: begin
                ra_en = 1'b1;
            end
            ST_NRM_RD: begin
                ra_en   = 1'b1;
                ra_addr = col_q;
            end
            ST_NRM_GO: begin
                div_go = 1'b1;
            end
            ST_NRM_WAIT: begin
                if (div_done) begin
                    wb_en   = 1'b1;
                    wb_we   = 1'b1;
                    wb_addr = col_q;
                    wb_d    = div_quo;
                end
            end
            ST_RUN: begin
                ra_en   = bc_valid_i;
                ra_addr = bc_col_i;
                if (s1_v_q) begin
                    wb_en   = 1'b1;
                    wb_we   = 1'b1;
                    wb_addr = s1_col_q;
                    wb_d    = alu_res;
                end
            end
            ST_RET_RD: begin
                wb_en   = 1'b1;
                wb_addr = LAST_COL;
            end
            default: ;
        endcase
    end

    // Instruction decode and sequencing.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    unique case (ph)
                        PH_ELIM: st_d = pos_equal ? ST_DEN_RD : ST_FAC_RD;
                        PH_RET:  st_d = pos_equal ? ST_RET_RD : ST_DONE;
                        default: st_d = ST_DONE;
                    endcase
                end
            end
            ST_FAC_RD:   st_d = ST_FAC_CAP;
            ST_FAC_CAP:  st_d = ST_RUN;
            ST_RUN:      st_d = run_last ? ST_DONE : ST_RUN;
            ST_DEN_RD:   st_d = ST_DEN_CAP;
            ST_DEN_CAP:  st_d = (ra_q == '0) ? ST_DONE : ST_NRM_RD;
            ST_NRM_RD:   st_d = ST_NRM_GO;
            ST_NRM_GO:   st_d = ST_NRM_WAIT;
            ST_NRM_WAIT: begin
                if (div_done) begin
                    st_d = (col_q == LAST_COL) ? ST_DONE : ST_NRM_RD;
                end
            end
            ST_RET_RD:   st_d = ST_RET_OUT;
            ST_RET_OUT:  st_d = ST_DONE;
            ST_DONE:     st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    // State, scalar registers and the elimination pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            col_q    <= '0;
            cnt_q    <= '0;
            fac_q    <= '0;
            den_q    <= '0;
            err_q    <= 1'b0;
            s1_v_q   <= 1'b0;
            s1_col_q <= '0;
            s1_b_q   <= '0;
        end else begin
            st_q   <= st_d;
            s1_v_q <= (st_q == ST_RUN) && bc_valid_i && !run_last;
            if (bc_valid_i) begin
                s1_col_q <= bc_col_i;
                s1_b_q   <= bc_data_i;
            end
            if (st_q == ST_IDLE && start_i) begin
                err_q <= 1'b0;
            end
            if (st_q == ST_FAC_CAP) begin
                fac_q <= ra_q;
                cnt_q <= '0;
            end
            if (st_q == ST_RUN && s1_v_q) begin
                cnt_q <= cnt_q + AW'(1);
            end
            if (st_q == ST_DEN_CAP) begin
                den_q <= ra_q;
                col_q <= '0;
                if (ra_q == '0) begin
                    err_q <= 1'b1;
                end
            end
            if (st_q == ST_NRM_WAIT && div_done) begin
                col_q <= col_q + AW'(1);
            end
        end
    end

    // Outputs.
    assign done_o      = (st_q == ST_DONE);
    assign nrm_valid_o = (st_q == ST_NRM_WAIT) && div_done;
    assign nrm_col_o   = col_q;
    assign nrm_data_o  = div_quo;
    assign ret_valid_o = (st_q == ST_RET_OUT);
    assign ret_data_o  = wb_q;
    assign div_err_o   = err_q;

endmodule

// File: rtl/gj_row_engine_chk.sv
// Protocol checks for gj_row_engine, attached by bind.
module gj_row_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic nrm_valid,
    input logic ret_valid,
    input logic div_err,
    input logic equal
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                   // R3
    AST_NRM_OWNER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        nrm_valid |-> equal);                              // R4
    AST_NRM_NOT_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> !nrm_valid);                           // R5
    AST_RET_OWNER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> equal);                              // R8
    AST_RET_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> (done && !ret_valid));               // R8
    AST_STREAMS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(nrm_valid && ret_valid));                        // R9

endmodule

bind gj_row_engine gj_row_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done_o),
    .nrm_valid (nrm_valid_o),
    .ret_valid (ret_valid_o),
    .div_err   (div_err_o),
    .equal     (pos_equal)
);

// File: tb/gj_row_engine_test.sv
`timescale 1ns/1ps
module gj_row_engine_test;

    localparam int N    = 3;
    localparam int ID   = 2;
    localparam int DW   = 24;
    localparam int FRAC = 16;
    localparam int COLS = N + 1;
    localparam int AW   = $clog2(COLS);
    localparam int IDW  = AW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     phase = '0;
    logic [IDW-1:0] ref_row = '0;
    logic           start = 1'b0;
    logic           ld_valid = 1'b0;
    logic [AW-1:0]  ld_col = '0;
    logic [DW-1:0]  ld_data = '0;
    logic           bc_valid = 1'b0;
    logic [AW-1:0]  bc_col = '0;
    logic [DW-1:0]  bc_data = '0;
    logic           done_o, nrm_valid_o, ret_valid_o, div_err_o;
    logic [AW-1:0]  nrm_col_o;
    logic [DW-1:0]  nrm_data_o, ret_data_o;

    gj_row_engine #(.N_ROWS(N), .ROW_ID(ID), .DW(DW), .FRAC(FRAC)) uut (
        .clk(clk), .rst_n(rst_n), .phase_i(phase), .ref_row_i(ref_row),
        .start_i(start), .ld_valid_i(ld_valid), .ld_col_i(ld_col),
        .ld_data_i(ld_data), .bc_valid_i(bc_valid), .bc_col_i(bc_col),
        .bc_data_i(bc_data), .done_o(done_o), .nrm_valid_o(nrm_valid_o),
        .nrm_col_o(nrm_col_o), .nrm_data_o(nrm_data_o),
        .ret_valid_o(ret_valid_o), .ret_data_o(ret_data_o),
        .div_err_o(div_err_o)
    );

    always #10 clk = ~clk;

    int          checks = 0;
    int          fails = 0;
    bit          finished = 0;
    int unsigned seed = 32'h1234_5678;
    int          cyc = 0;
    longint      m [COLS];

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic longint sat(longint v);
        if (v > 64'sd8388607) return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    function automatic longint sx(logic [DW-1:0] x);
        return longint'($signed(x));
    endfunction

    function automatic longint div_m(longint n, longint d);
        return sat((n * 65536) / d);
    endfunction

    function automatic longint elim_m(longint r, longint f, longint b);
        return sat(r - ((f * b) >>> 16));
    endfunction

    function automatic longint rnd(int range);
        seed = seed * 32'd1103515245 + 32'd12345;
        return longint'((seed >> 8) % range) - longint'(range / 2);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_op(input int ph, input int rr);
        @(negedge clk);
        phase = 2'(ph);
        ref_row = IDW'(rr);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic load_row(input int rr, input longint v [COLS]);
        for (int c = 0; c < COLS; c++) begin
            @(negedge clk);
            phase = 2'd1;
            ref_row = IDW'(rr);
            ld_valid = 1'b1;
            ld_col = AW'(c);
            ld_data = v[c][DW-1:0];
        end
        @(negedge clk);
        ld_valid = 1'b0;
        if (rr == ID) m = v;
    endtask

    task automatic check_ack(input int ph, input int rr);
        start_op(ph, rr);
        chk(done_o == 1'b1, "R3 ack done", done_o, 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R3 done width", done_o, 0);
    endtask

    task automatic do_return(input int rr, input string req);
        start_op(3, rr);
        if (rr == ID) begin
            chk(ret_valid_o == 1'b0 && done_o == 1'b0, "R8 early", ret_valid_o, 0);
            @(negedge clk);
            chk(ret_valid_o == 1'b1, "R8 ret_valid", ret_valid_o, 1);
            chk(sx(ret_data_o) == m[COLS-1], req, sx(ret_data_o), m[COLS-1]);
            @(negedge clk);
            chk(done_o == 1'b1 && ret_valid_o == 1'b0, "R8 done after ret", done_o, 1);
        end else begin
            chk(done_o == 1'b1 && ret_valid_o == 1'b0, "R9 non-owner return", ret_valid_o, 0);
        end
    endtask

    task automatic do_norm(input string req);
        longint d = m[ID-1];
        longint q [COLS];
        int     got = 0;
        bit     seen_done = 0;
        if (d != 0) for (int c = 0; c < COLS; c++) q[c] = div_m(m[c], d);
        start_op(2, ID);
        for (int k = 0; k < 4000 && !seen_done; k++) begin
            if (nrm_valid_o) begin
                if (got < COLS) begin
                    chk(int'(nrm_col_o) == got, "R4 column order", nrm_col_o, got);
                    chk(sx(nrm_data_o) == q[got], req, sx(nrm_data_o), q[got]);
                end
                got++;
            end
            if (done_o) seen_done = 1;
            else @(negedge clk);
        end
        chk(seen_done, "R4 done seen", seen_done, 1);
        if (d == 0) begin
            chk(div_err_o == 1'b1, "R5 div_err", div_err_o, 1);
            chk(got == 0, "R5 no stream", got, 0);
        end else begin
            chk(got == COLS, "R4 element count", got, COLS);
            chk(div_err_o == 1'b0, "R4 no error", div_err_o, 0);
            m = q;
        end
    endtask

    task automatic do_elim(input int rr, input longint b [COLS], input int rot, input bit stray);
        longint f = m[rr-1];
        longint nm [COLS];
        nm = m;
        start_op(2, rr);
        if (stray) begin
            bc_valid = 1'b1;
            bc_col = AW'(rot % COLS);
            bc_data = 24'h7FFFFF;
        end
        @(negedge clk);
        bc_valid = 1'b0;
        @(negedge clk);
        for (int k = 0; k < COLS; k++) begin
            int c = (k + rot) % COLS;
            bc_valid = 1'b1;
            bc_col = AW'(c);
            bc_data = b[c][DW-1:0];
            nm[c] = elim_m(m[c], f, b[c]);
            @(negedge clk);
        end
        bc_valid = 1'b0;
        chk(done_o == 1'b0, "R6 done not early", done_o, 0);
        @(negedge clk);
        chk(done_o == 1'b1, "R6 done timing", done_o, 1);
        m = nm;
    endtask

    initial begin
        longint v [COLS];
        longint g [COLS];
        longint b [COLS];

        repeat (3) @(negedge clk);
        chk({done_o, nrm_valid_o, ret_valid_o, div_err_o} == 4'b0, "R1 in reset",
            {done_o, nrm_valid_o, ret_valid_o, div_err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({done_o, nrm_valid_o, ret_valid_o, div_err_o} == 4'b0, "R1 after reset",
            {done_o, nrm_valid_o, ret_valid_o, div_err_o}, 0);

        // Sweep: load, foreign load, acks, returns, elimination, normalization.
        for (int t = 0; t < 24; t++) begin
            for (int c = 0; c < COLS; c++) begin
                v[c] = rnd(524288);
                if (v[c] == 0) v[c] = 1;
                g[c] = rnd(524288) + 7;
                b[c] = rnd(262144);
            end
            load_row(ID, v);
            load_row((t % 2 == 0) ? 1 : 3, g);          // R2 foreign load ignored
            check_ack(t % 2, ID);
            do_return(ID, "R2 rhs after foreign load");
            do_return((t % 2 == 0) ? 3 : 1, "R9");
            do_elim((t % 2 == 0) ? 1 : 3, b, t, (t % 3 == 0));  // R6, R7
            do_return(ID, "R6 rhs after elimination");
            do_norm("R4 quotient after elimination");
            do_return(ID, "R4 rhs after normalize");
        end

        // R4 saturation: tiny diagonal drives quotients to both limits.
        v[0] = 64'sd6553600; v[1] = 1; v[2] = -64'sd6553600; v[3] = 0;
        load_row(ID, v);
        do_norm("R4 saturated quotient");

        // R6 saturation on both sides.
        v[0] = -64'sd8323072; v[1] = 64'sd8323072; v[2] = -64'sd8323072; v[3] = 64'sd100;
        load_row(ID, v);
        b[0] = 64'sd8323072; b[1] = 64'sd8323072; b[2] = -64'sd8323072; b[3] = 64'sd65536;
        do_elim(1, b, 1, 1'b0);
        do_return(ID, "R6 rhs saturated path");
        m[1] = 64'sd65536;
        load_row(ID, m);
        do_norm("R6 saturated row via quotients");

        // R5 zero diagonal: no stream, row intact, error clears on next start.
        v[0] = 64'sd1000; v[1] = 0; v[2] = -64'sd5000; v[3] = 64'sd123456;
        load_row(ID, v);
        do_norm("R5 unreachable");
        do_return(ID, "R5 row unchanged");
        chk(div_err_o == 1'b0, "R5 error cleared by start", div_err_o, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule